// File: doc/BRIEF.md
# Signed Arithmetic-Logic Unit with Condition Flags

This block is a purely combinational arithmetic-logic unit for two's-complement operands whose width is set by a parameter. One 4-bit operation code selects every function. The unit has no separate shifter control. The functions are pass-through, four bit-wise logic functions, increment, decrement, addition, subtraction, arithmetic shifts in both directions and rotates in both directions. Operations that belong together share their upper opcode bits:

| Opcode group | Function family |
|---|---|
| `00xx` | pass-through and the unused codes |
| `01xx` | logic |
| `10xx` | arithmetic |
| `11xx` | shift and rotate |

Next to the result, the unit produces an 8-bit flag word. Seven flags compare the result with zero and one as a signed number. The eighth flag reports signed overflow for the operations that can overflow. A surrounding datapath drives the operands and the opcode, and reads the result and flags in the same cycle. The shift amount is `$clog2(N)` bits wide, and `N` is assumed to be a power of two not less than 2.

Top module: `sig_alu`

## Requirements
- R1: Opcode 0000 returns `a_in` unchanged, with flag bit 7 (overflow) clear.
- R2: Opcodes 0100, 0101, 0110 and 0111 return `a_in AND b_in`, `a_in OR b_in`, `a_in XOR b_in` and `NOT a_in` respectively, with overflow clear.
- R3: Opcode 1000 returns `a_in+1` and opcode 1001 returns `a_in-1`, both modulo 2^N. Overflow is set exactly when the signed result lies outside the N-bit signed range.
- R4: Opcode 1010 returns `a_in+b_in` and opcode 1011 returns `a_in-b_in`, both modulo 2^N. Overflow is set exactly when the true signed sum or difference lies outside the N-bit signed range.
- R5: Opcode 1100 shifts `a_in` left by `shamt` and fills the vacated low bits with zeros. Overflow is set when any bit shifted out, or the new sign bit, differs from the original sign bit.
- R6: Opcode 1101 shifts `a_in` right by `shamt` and replicates the sign bit, with overflow clear.
- R7: Opcode 1110 rotates `a_in` left by `shamt` and opcode 1111 rotates it right by `shamt`, with overflow clear.
- R8: A shift or rotate (opcodes 11xx) with `shamt`=0 returns `a_in` unchanged with overflow clear.
- R9: Opcodes 0001, 0010 and 0011 return an all-zero result. Flags 0 to 6 follow from that zero result and overflow is clear.
- R10: For every opcode, flag bits 0 to 6 describe the result read as signed. Bit 0 is zero, bit 1 is non-zero, bit 2 is equal to one and bit 3 is negative. Bit 4 is greater than zero, bit 5 is less than or equal to zero, and bit 6 is greater than or equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | N | First operand, signed |
| b_in | input | N | Second operand, signed |
| shamt | input | $clog2(N) | Shift or rotate distance |
| opcode | input | 4 | Operation select |
| result | output | N | Operation result |
| flags | output | 8 | Condition flags, bit 7 is overflow |

## Verification
The bench builds the unit at its default width of 16. At this width, the signed limits 0x7FFF and 0x8000 and every shift distance from 0 to 15 can be reached directly. This covers overflow at both ends of the range for all four arithmetic codes, a left shift that keeps the sign against one that loses it, and full-width rotates. A directed list of corner vectors is followed by several hundred pseudo-random operand and opcode mixes. Each one is compared against an integer model of the requirements.

// File: rtl/sig_alu_pkg.sv
// Package sig_alu_pkg
// Shared opcode values and flag bit positions for the signed ALU.
// Assumes: opcode groups are decoded by their two upper bits.
package sig_alu_pkg;

    typedef enum logic [3:0] {
        OPC_PASS = 4'b0000,
        OPC_AND  = 4'b0100,
        OPC_OR   = 4'b0101,
        OPC_XOR  = 4'b0110,
        OPC_INV  = 4'b0111,
        OPC_INC  = 4'b1000,
        OPC_DEC  = 4'b1001,
        OPC_ADD  = 4'b1010,
        OPC_SUB  = 4'b1011,
        OPC_SHL  = 4'b1100,
        OPC_SHR  = 4'b1101,
        OPC_ROL  = 4'b1110,
        OPC_ROR  = 4'b1111
    } alu_opc_e;

    // Opcode group taken from opcode[3:2]
    typedef enum logic [1:0] {
        GRP_MISC  = 2'b00,
        GRP_LOGIC = 2'b01,
        GRP_ARITH = 2'b10,
        GRP_SHIFT = 2'b11
    } alu_grp_e;

    localparam int FLG_ZERO   = 0;
    localparam int FLG_NZERO  = 1;
    localparam int FLG_ONE    = 2;
    localparam int FLG_NEG    = 3;
    localparam int FLG_POS    = 4;
    localparam int FLG_NONPOS = 5;
    localparam int FLG_NONNEG = 6;
    localparam int FLG_OVF    = 7;
    localparam int FLG_W      = 8;

endpackage

// File: rtl/sig_alu_logic.sv
// Module sig_alu_logic
// Bit-wise logic unit for the 01xx opcode group; sel is opcode[1:0].
// Assumes: no overflow can arise here, so none is produced.
module sig_alu_logic #(
    parameter int N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [1:0]   sel,
    output logic [N-1:0] y
);

    // Select one bit-wise function of the operands
    always_comb begin
        unique case (sel)
            2'b00:   y = a & b;
            2'b01:   y = a | b;
            2'b10:   y = a ^ b;
            default: y = ~a;
        endcase
    end

endmodule

// File: rtl/sig_alu_arith.sv
// Module sig_alu_arith
// Adder/subtractor for the 10xx opcode group.
// sel[1] picks b over the constant one, sel[0] selects subtraction.
// Assumes two's-complement operands; overflow is judged from sign bits.
module sig_alu_arith #(
    parameter int N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [1:0]   sel,
    output logic [N-1:0] y,
    output logic         ovf
);

    localparam int MSB = N - 1;
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] opnd;

    // Second operand: port b or the constant one
    always_comb opnd = sel[1] ? b : ONE;

    // Sum or difference with signed overflow detection
    always_comb begin
        if (sel[0]) begin
            y   = a - opnd;
            ovf = (a[MSB] != opnd[MSB]) && (y[MSB] != a[MSB]);
        end else begin
            y   = a + opnd;
            ovf = (a[MSB] == opnd[MSB]) && (y[MSB] != a[MSB]);
        end
    end

endmodule

// File: rtl/sig_alu_shift.sv
// Module sig_alu_shift
// Shifter/rotator for the 11xx opcode group.
// sel[1] selects rotate, sel[0] selects rightward movement.
// Assumes N is a power of two, so every shamt value is below N.
module sig_alu_shift #(
    parameter int N  = 16,
    parameter int XW = $clog2(N)
) (
    input  logic [N-1:0]  a,
    input  logic [XW-1:0] amt,
    input  logic [1:0]    sel,
    output logic [N-1:0]  y,
    output logic          ovf
);

    localparam int MSB = N - 1;

    logic [2*N-1:0] dbl_l;
    logic [2*N-1:0] dbl_r;
    logic [N-1:0]   top_mask;
    logic [N-1:0]   sgn_diff;

    // Doubled operand moved both ways gives the rotate results
    always_comb begin
        dbl_l = {a, a} << amt;
        dbl_r = {a, a} >> amt;
    end

    // Mask of the bits shifted out plus the new sign position
    always_comb begin
        top_mask = {N{1'b1}} << (MSB - int'(amt));
        sgn_diff = a ^ {N{a[MSB]}};
    end

    // Choose among the four movements; only a left shift may overflow
    always_comb begin
        ovf = 1'b0;
        unique case (sel)
            2'b00: begin
                y   = a << amt;
                ovf = |(sgn_diff & top_mask);
            end
            2'b01:   y = $signed(a) >>> amt;
            2'b10:   y = dbl_l[2*N-1:N];
            default: y = dbl_r[N-1:0];
        endcase
    end

endmodule

// File: rtl/sig_alu_flags.sv
// Module sig_alu_flags
// Derives the condition flags from a result and an overflow bit.
// Assumes the result is a two's-complement number.
module sig_alu_flags
    import sig_alu_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]     res,
    input  logic             ovf,
    output logic [FLG_W-1:0] flg
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic is_zero;
    logic is_neg;

    // Basic properties of the result
    always_comb begin
        is_zero = (res == '0);
        is_neg  = res[N-1];
    end

    // Assemble the flag word
    always_comb begin
        flg[FLG_ZERO]   = is_zero;
        flg[FLG_NZERO]  = ~is_zero;
        flg[FLG_ONE]    = (res == ONE);
        flg[FLG_NEG]    = is_neg;
        flg[FLG_POS]    = ~is_neg & ~is_zero;
        flg[FLG_NONPOS] = is_neg | is_zero;
        flg[FLG_NONNEG] = ~is_neg;
        flg[FLG_OVF]    = ovf;
    end

endmodule

// File: rtl/sig_alu.sv
// Module sig_alu
// Combinational signed ALU: one 4-bit opcode selects logic, arithmetic,
// shift or rotate. It also produces eight condition flags.
// Assumes N is a power of two and at least 2; it holds no state.
module sig_alu
    import sig_alu_pkg::*;
#(
    parameter int N  = 16,
    parameter int XW = $clog2(N)
) (
    input  logic [N-1:0]  a_in,
    input  logic [N-1:0]  b_in,
    input  logic [XW-1:0] shamt,
    input  logic [3:0]    opcode,
    output logic [N-1:0]  result,
    output logic [7:0]    flags
);

    logic [N-1:0] y_logic, y_arith, y_shift;
    logic         v_arith, v_shift;
    logic         v_sel;
    alu_grp_e     grp;

    sig_alu_logic #(.N(N)) u_logic (
        .a(a_in), .b(b_in), .sel(opcode[1:0]), .y(y_logic)
    );

    sig_alu_arith #(.N(N)) u_arith (
        .a(a_in), .b(b_in), .sel(opcode[1:0]), .y(y_arith), .ovf(v_arith)
    );

    sig_alu_shift #(.N(N), .XW(XW)) u_shift (
        .a(a_in), .amt(shamt), .sel(opcode[1:0]), .y(y_shift), .ovf(v_shift)
    );

    // Decode the opcode group
    always_comb grp = alu_grp_e'(opcode[3:2]);

    // Route the group result and its overflow to the output
    always_comb begin
        v_sel = 1'b0;
        unique case (grp)
            GRP_MISC:  result = (opcode[1:0] == 2'b00) ? a_in : '0;
            GRP_LOGIC: result = y_logic;
            GRP_ARITH: begin
                result = y_arith;
                v_sel  = v_arith;
            end
            default: begin
                result = y_shift;
                v_sel  = v_shift;
            end
        endcase
    end

    sig_alu_flags #(.N(N)) u_flags (
        .res(result), .ovf(v_sel), .flg(flags)
    );

endmodule

// File: rtl/sig_alu_chk.sv
// Module sig_alu_chk
// Port-level checks of the signed ALU. It is attached to every
// sig_alu instance by the bind statement at the end of this file.
// Assumes combinational settling; uses immediate checks only.
module sig_alu_chk #(
    parameter int N  = 16,
    parameter int XW = $clog2(N)
) (
    input logic [N-1:0]  a_in,
    input logic [N-1:0]  b_in,
    input logic [XW-1:0] shamt,
    input logic [3:0]    opcode,
    input logic [N-1:0]  result,
    input logic [7:0]    flags
);

    // Relate the outputs to the inputs for every opcode
    always_comb begin
        if (opcode == 4'b0000) begin
            AST_PASS_THROUGH: assert (result == a_in && !flags[7]) else $error("pass-through broken"); // R1
        end
        if (opcode == 4'b1010) begin
            AST_ADD_WRAP: assert (result == N'(a_in + b_in)) else $error("add result wrong"); // R4
        end
        if (opcode[3] == 1'b0 || opcode[3:1] == 3'b111 || opcode == 4'b1101) begin
            AST_NO_OVERFLOW: assert (!flags[7]) else $error("overflow on a non-overflowing opcode"); // R7
        end
        if (opcode[3:2] == 2'b11 && shamt == '0) begin
            AST_ZERO_DISTANCE: assert (result == a_in && !flags[7]) else $error("zero shift altered operand"); // R8
        end
        if (opcode != 4'b0000 && opcode[3:2] == 2'b00) begin
            AST_UNUSED_CODE: assert (result == '0 && flags[0] && !flags[7]) else $error("unused opcode not zero"); // R9
        end
        AST_ZERO_EXCL: assert (flags[0] != flags[1]) else $error("zero and non-zero flags agree"); // R10
        AST_SIGN_EXCL: assert (flags[3] != flags[6]) else $error("negative and non-negative flags agree"); // R10
        AST_LE_SPLIT: assert (flags[5] != flags[4]) else $error("positive and non-positive flags agree"); // R10
    end

endmodule

bind sig_alu sig_alu_chk #(.N(N), .XW(XW)) chk_i (
    .a_in(a_in), .b_in(b_in), .shamt(shamt), .opcode(opcode),
    .result(result), .flags(flags)
);

// File: tb/sig_alu_tb_top.sv
// Bench sig_alu_tb_top
// Drives directed and pseudo-random vectors into the ALU at N=16 and
// compares each clock against an integer reference model.
module sig_alu_tb_top;

    localparam int N  = 16;
    localparam int XW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  a, b;
    logic [XW-1:0] x;
    logic [3:0]    op;
    logic [N-1:0]  res;
    logic [7:0]    flg;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    sig_alu #(.N(N)) dut_i (
        .a_in(a), .b_in(b), .shamt(x), .opcode(op), .result(res), .flags(flg)
    );

    // Requirement tag that governs an opcode and distance
    function automatic string req_of(input logic [3:0] o, input logic [XW-1:0] d);
        if (o[3:2] == 2'b11 && d == 0) return "R8";
        case (o)
            4'b0000: return "R1";
            4'b0001, 4'b0010, 4'b0011: return "R9";
            4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R2";
            4'b1000, 4'b1001: return "R3";
            4'b1010, 4'b1011: return "R4";
            4'b1100: return "R5";
            4'b1101: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Behavioural model: expected result and overflow
    task automatic model(input logic [3:0] o, input logic [N-1:0] va, input logic [N-1:0] vb,
                         input int d, output logic [N-1:0] r, output logic v);
        int  sa, sb, t;
        longint big;
        sa = int'($signed(va));
        sb = int'($signed(vb));
        v  = 1'b0;
        t  = 0;
        r  = '0;
        case (o)
            4'b0000: r = va;
            4'b0100: r = va & vb;
            4'b0101: r = va | vb;
            4'b0110: r = va ^ vb;
            4'b0111: r = ~va;
            4'b1000, 4'b1001, 4'b1010, 4'b1011: begin
                case (o)
                    4'b1000: t = sa + 1;
                    4'b1001: t = sa - 1;
                    4'b1010: t = sa + sb;
                    default: t = sa - sb;
                endcase
                r = t[N-1:0];
                v = (t > 32767) || (t < -32768);
            end
            4'b1100: begin
                big = longint'(sa) * (longint'(1) << d);
                r = big[N-1:0];
                v = (big > 32767) || (big < -32768);
            end
            4'b1101: begin
                t = sa;
                for (int i = 0; i < d; i++) t = (t < 0) ? -((-t + 1) / 2) : t / 2;
                r = t[N-1:0];
            end
            4'b1110: for (int i = 0; i < N; i++) r[(i + d) % N] = va[i];
            4'b1111: for (int i = 0; i < N; i++) r[i] = va[(i + d) % N];
            default: r = '0;
        endcase
    endtask

    // Flags from the expected result read as signed
    function automatic logic [7:0] flags_of(input logic [N-1:0] r, input logic v);
        int s;
        s = int'($signed(r));
        return {v, s >= 0, s <= 0, s > 0, s < 0, s == 1, s != 0, s == 0};
    endfunction

    task automatic check(input string tag, input logic [N-1:0] er, input logic [7:0] ef);
        n_cmp++;
        if (res !== er || flg !== ef) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h x=%0d: got res=%h flags=%b, expected res=%h flags=%b",
                     tag, op, a, b, x, res, flg, er, ef);
        end
    endtask

    // Apply one vector away from the edge, compare after the next edge
    task automatic run(input logic [3:0] o, input logic [N-1:0] va, input logic [N-1:0] vb,
                       input int d);
        logic [N-1:0] er;
        logic ev;
        @(negedge clk);
        op = o; a = va; b = vb; x = XW'(d);
        model(o, va, vb, d, er, ev);
        @(posedge clk);
        #1;
        check(req_of(o, XW'(d)), er, flags_of(er, ev));
    endtask

    initial begin
        op = '0; a = '0; b = '0; x = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state: all-zero inputs give pass-through of zero, flags 0x61 (R1, R10)
        check("R1", 16'h0000, 8'b0110_0001);
        // R1 identity
        run(4'b0000, 16'h8000, 0, 0);
        run(4'b0000, 16'h0001, 0, 0);
        // R2 logic
        run(4'b0100, 16'hF0F0, 16'h3C3C, 0);
        run(4'b0101, 16'hF0F0, 16'h3C3C, 0);
        run(4'b0110, 16'hFFFF, 16'h0001, 0);
        run(4'b0111, 16'hFFFF, 0, 0);
        // R3 increment/decrement incl. overflow edges
        run(4'b1000, 16'h7FFF, 0, 0);
        run(4'b1000, 16'hFFFF, 0, 0);
        run(4'b1001, 16'h8000, 0, 0);
        run(4'b1001, 16'h0002, 0, 0);
        // R4 add/sub incl. both overflow directions
        run(4'b1010, 16'h7FFF, 16'h0001, 0);
        run(4'b1010, 16'h8000, 16'hFFFF, 0);
        run(4'b1010, 16'h1234, 16'hEDCC, 0);
        run(4'b1011, 16'h8000, 16'h0001, 0);
        run(4'b1011, 16'h7FFF, 16'hFFFF, 0);
        run(4'b1011, 16'h0005, 16'h0004, 0);
        // R5 left shift: sign kept, sign lost, full distance
        run(4'b1100, 16'h4000, 0, 1);
        run(4'b1100, 16'hC000, 0, 1);
        run(4'b1100, 16'h0001, 0, 15);
        run(4'b1100, 16'hFFFF, 0, 15);
        run(4'b1100, 16'h00FF, 0, 7);
        run(4'b1100, 16'h00FF, 0, 8);
        // R6 right shift with sign fill
        run(4'b1101, 16'h8000, 0, 15);
        run(4'b1101, 16'h7FFF, 0, 14);
        run(4'b1101, 16'hF00F, 0, 4);
        // R7 rotates
        run(4'b1110, 16'h8001, 0, 1);
        run(4'b1111, 16'h8001, 0, 1);
        run(4'b1110, 16'h1234, 0, 15);
        run(4'b1111, 16'h1234, 0, 12);
        // R8 zero distance for all four movements
        for (int k = 12; k < 16; k++) run(4'(k), 16'h8001, 0, 0);
        // R9 unused codes
        run(4'b0001, 16'hFFFF, 16'hFFFF, 3);
        run(4'b0010, 16'h1234, 16'h5678, 0);
        run(4'b0011, 16'h8000, 16'h8000, 15);
        // R10 flag boundaries: results of one, minus one, zero
        run(4'b1010, 16'h0000, 16'h0001, 0);
        run(4'b1001, 16'h0000, 0, 0);
        run(4'b0110, 16'hABCD, 16'hABCD, 0);
        // Pseudo-random mix across all opcodes
        for (int k = 0; k < 600; k++) begin
            logic [3:0] ro;
            ro = 4'($urandom_range(0, 15));
            run(ro, N'($urandom), N'($urandom), int'($urandom_range(0, 15)));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule